// File: doc/BRIEF.md
# PLL Control and Lock-Status Register Unit

This block is the digital register face of a single phase-locked loop. It holds a control word that powers the loop down, bypasses it, and sets three dividers. It also reports a status word with a lock flag and an error flag. The analog loop is not modelled. The block replaces the loop's relock time with a counter of reference-clock cycles. It decodes the divider fields into the effective multiply factor and the total divide factor, so the output-to-reference ratio can be read directly as numerator and denominator.

The dividers are stored in coded form. The input divider holds its factor minus one. The feedback field holds half its multiply factor minus one. The output divider holds the base-2 logarithm of its factor.

Any write that leaves the loop running drops lock. Lock returns only after the relock count has run out. If a write sets a feedback-to-input ratio outside the legal VCO window, the error flag is raised and lock is held off until a later write clears the condition.

Top module: `pll_ctrl_regs`

## Requirements
- R1: After reset, the control word reads 0x00000001 (powered down, not bypassed, all dividers zero), and the status word reads 0.
- R2: A control write stores bit 0 (power-down), bit 1 (bypass), bits 3:2 (output divider), bits 8:4 (input divider), bits 15:9 (feedback) and bits 23:20 (band). The control word reads back as the written value ANDed with 0x00F0FFFF.
- R3: With power-down and bypass both clear, out_mode is 2 (active). mult_factor equals 2*(feedback+1), and div_factor equals (input divider+1)*2^(output divider).
- R4: With bypass set, out_mode is 1, mult_factor is 1 and div_factor is 1, whatever the power-down bit holds.
- R5: With bypass clear and power-down set, out_mode is 0, mult_factor is 0 and div_factor is 1.
- R6: A control write with an active mode and a legal ratio clears lock at the write edge. Lock rises at exactly the LOCK_CYCLES-th rising edge after that write edge.
- R7: A new control write while the relock count runs restarts it, including a write at the very edge where the count would have expired.
- R8: An active control write is legal only when VCO_RATIO_MIN*(input divider+1) <= 2*(feedback+1) <= VCO_RATIO_MAX*(input divider+1). An illegal write sets the error flag (status bit 1) and keeps lock low until a legal write, which clears the error.
- R9: A control write that powers down or bypasses the loop clears both lock and error, and no relock follows.
- R10: The word index selects the register: 0 control, 1 status (bit 0 lock, bit 1 error), 2 frequency measure, 3 monitor. Writes to indices 1, 2 and 3 change neither the control word nor the flags. Indices 2 and 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_word | input | 2 | Register word index (byte offset / 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected word |
| mult_factor | output | 9 | Effective feedback multiply factor |
| div_factor | output | 9 | Effective total divide factor |
| out_mode | output | 2 | 0 off, 1 bypass, 2 active |
| pll_locked | output | 1 | Lock flag |
| pll_error | output | 1 | Illegal-ratio flag |

## Verification
Two timer events can fall on the same edge: the relock count expiring and a fresh control write arriving. The bench provokes this by waiting exactly LOCK_CYCLES-1 edges after a legal write and then issuing a second write on the next edge. It expects lock to stay low at that edge and to rise a full LOCK_CYCLES edges after the second write. A write to a status or unused word while lock is high is also issued. The bench judges that lock stays high and the control word is unchanged.

// File: rtl/pll_ctrl_pkg.sv
package pll_ctrl_pkg;
  localparam int ODIV_LSB = 2;
  localparam int ODIV_W   = 2;
  localparam int IDIV_LSB = 4;
  localparam int IDIV_W   = 5;
  localparam int FB_LSB   = 9;
  localparam int FB_W     = 7;
  localparam int BAND_LSB = 20;
  localparam int BAND_W   = 4;
  localparam int MULT_W   = FB_W + 2;
  localparam int DEN_W    = IDIV_W + (2 ** ODIV_W);

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_BYPASS = 2'd1,
    MODE_ACTIVE = 2'd2
  } pll_mode_e;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_MEAS = 2'd2,
    SEL_MON  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [BAND_W-1:0] band;
    logic [FB_W-1:0]   fb;
    logic [IDIV_W-1:0] idiv;
    logic [ODIV_W-1:0] odiv;
    logic              bypass;
    logic              pdown;
  } pll_ctrl_t;

  function automatic pll_ctrl_t ctrl_unpack(logic [31:0] w);
    pll_ctrl_t c;
    c.pdown  = w[0];
    c.bypass = w[1];
    c.odiv   = w[ODIV_LSB +: ODIV_W];
    c.idiv   = w[IDIV_LSB +: IDIV_W];
    c.fb     = w[FB_LSB +: FB_W];
    c.band   = w[BAND_LSB +: BAND_W];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_pack(pll_ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[0] = c.pdown;
    w[1] = c.bypass;
    w[ODIV_LSB +: ODIV_W] = c.odiv;
    w[IDIV_LSB +: IDIV_W] = c.idiv;
    w[FB_LSB +: FB_W]     = c.fb;
    w[BAND_LSB +: BAND_W] = c.band;
    return w;
  endfunction

  function automatic int fb_mult(logic [FB_W-1:0] f);
    return 2 * (int'(f) + 1);
  endfunction

  function automatic int in_div(logic [IDIV_W-1:0] f);
    return int'(f) + 1;
  endfunction

  function automatic int out_div(logic [ODIV_W-1:0] f);
    return 1 << int'(f);
  endfunction

  function automatic logic vco_legal(logic [FB_W-1:0] f, logic [IDIV_W-1:0] d,
                                     int vmin, int vmax);
    int m;
    int q;
    m = fb_mult(f);
    q = in_div(d);
    return (m >= vmin * q) && (m <= vmax * q);
  endfunction
endpackage

// File: rtl/pll_ctrl_reg.sv
module pll_ctrl_reg
  import pll_ctrl_pkg::*;
#(
  parameter int VCO_RATIO_MIN = 18,
  parameter int VCO_RATIO_MAX = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  sel,
  input  logic [31:0] wdata,
  output pll_ctrl_t   ctrl_q,
  output logic        err_q,
  output logic        relock_start,
  output logic        relock_stop
);
  pll_ctrl_t wr_ctrl;
  logic      ctrl_wr;
  logic      wr_active;
  logic      wr_legal;

  assign wr_ctrl      = ctrl_unpack(wdata);
  assign ctrl_wr      = wr_en && (sel == SEL_CTRL);
  assign wr_active    = !wr_ctrl.pdown && !wr_ctrl.bypass;
  assign wr_legal     = vco_legal(wr_ctrl.fb, wr_ctrl.idiv, VCO_RATIO_MIN, VCO_RATIO_MAX);
  assign relock_start = ctrl_wr && wr_active && wr_legal;
  assign relock_stop  = ctrl_wr && !(wr_active && wr_legal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q       <= '0;
      ctrl_q.pdown <= 1'b1;
      err_q        <= 1'b0;
    end else if (ctrl_wr) begin
      ctrl_q <= wr_ctrl;
      err_q  <= wr_active && !wr_legal;
    end
  end

  a_r10_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel != SEL_CTRL) |=> ($stable(ctrl_q) && $stable(err_q)));
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
  parameter int LOCK_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  output logic locked,
  output logic expire
);
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign expire = run_q && (cnt_q == '0) && !start && !stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      locked <= 1'b0;
    end else if (start) begin
      cnt_q  <= CNT_W'(LOCK_CYCLES - 1);
      run_q  <= 1'b1;
      locked <= 1'b0;
    end else if (stop) begin
      run_q  <= 1'b0;
      locked <= 1'b0;
    end else if (expire) begin
      run_q  <= 1'b0;
      locked <= 1'b1;
    end else if (run_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!locked && !run_q));
  a_r6_no_lock_while_run: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> !locked);
endmodule

// File: rtl/pll_ratio_calc.sv
module pll_ratio_calc
  import pll_ctrl_pkg::*;
(
  input  logic                pdown,
  input  logic                bypass,
  input  logic [ODIV_W-1:0]   odiv,
  input  logic [IDIV_W-1:0]   idiv,
  input  logic [FB_W-1:0]     fb,
  output pll_mode_e           mode,
  output logic [MULT_W-1:0]   mult,
  output logic [DEN_W-1:0]    den
);
  always_comb begin
    if (bypass) begin
      mode = MODE_BYPASS;
      mult = MULT_W'(1);
      den  = DEN_W'(1);
    end else if (pdown) begin
      mode = MODE_OFF;
      mult = '0;
      den  = DEN_W'(1);
    end else begin
      mode = MODE_ACTIVE;
      mult = MULT_W'(fb_mult(fb));
      den  = DEN_W'(in_div(idiv) * out_div(odiv));
    end
  end

  always_comb begin
    if (mode == MODE_ACTIVE)
      a_r3_active_nonzero: assert (mult != '0 && den != '0);
  end
endmodule

// File: rtl/pll_ctrl_regs.sv
module pll_ctrl_regs
  import pll_ctrl_pkg::*;
#(
  parameter int LOCK_CYCLES   = 64,
  parameter int VCO_RATIO_MIN = 18,
  parameter int VCO_RATIO_MAX = 100
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_wr_en,
  input  logic [1:0]                   reg_word,
  input  logic [31:0]                  reg_wdata,
  output logic [31:0]                  reg_rdata,
  output logic [pll_ctrl_pkg::MULT_W-1:0] mult_factor,
  output logic [pll_ctrl_pkg::DEN_W-1:0]  div_factor,
  output logic [1:0]                   out_mode,
  output logic                         pll_locked,
  output logic                         pll_error
);
  pll_ctrl_t ctrl_q;
  pll_mode_e mode;
  logic      relock_start;
  logic      relock_stop;
  logic      relock_expire;
  logic      ctrl_wr;

  assign ctrl_wr = reg_wr_en && (reg_word == SEL_CTRL);

  pll_ctrl_reg #(.VCO_RATIO_MIN(VCO_RATIO_MIN), .VCO_RATIO_MAX(VCO_RATIO_MAX)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .sel(reg_word), .wdata(reg_wdata),
    .ctrl_q(ctrl_q), .err_q(pll_error),
    .relock_start(relock_start), .relock_stop(relock_stop)
  );

  pll_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(relock_start), .stop(relock_stop),
    .locked(pll_locked), .expire(relock_expire)
  );

  pll_ratio_calc u_calc (
    .pdown(ctrl_q.pdown), .bypass(ctrl_q.bypass), .odiv(ctrl_q.odiv),
    .idiv(ctrl_q.idiv), .fb(ctrl_q.fb),
    .mode(mode), .mult(mult_factor), .den(div_factor)
  );

  assign out_mode = mode;

  always_comb begin
    case (reg_word)
      SEL_CTRL: reg_rdata = ctrl_pack(ctrl_q);
      SEL_STAT: reg_rdata = {30'd0, pll_error, pll_locked};
      default:  reg_rdata = '0;
    endcase
  end

  a_r6_drop_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !pll_locked);
  a_r8_err_blocks_lock: assert property (@(posedge clk) disable iff (!rst_n)
    pll_error |-> !pll_locked);
  a_r7_rise_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_locked) |-> ($past(relock_expire) && !$past(ctrl_wr)));
  a_r4_bypass_unity: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.bypass |-> (mult_factor == 1 && div_factor == 1));
endmodule

// File: tb/test_pll_ctrl_regs.sv
module test_pll_ctrl_regs;
  localparam int LOCK_CYCLES = 64;
  localparam int VMIN = 18;
  localparam int VMAX = 100;
  localparam int MAX_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_word = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [8:0]  mult_factor;
  logic [8:0]  div_factor;
  logic [1:0]  out_mode;
  logic        pll_locked;
  logic        pll_error;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pll_ctrl_regs #(.LOCK_CYCLES(LOCK_CYCLES), .VCO_RATIO_MIN(VMIN), .VCO_RATIO_MAX(VMAX))
  i_pll_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_word(reg_word),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mult_factor(mult_factor),
    .div_factor(div_factor), .out_mode(out_mode), .pll_locked(pll_locked),
    .pll_error(pll_error)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic int e_mult(logic [31:0] v);
    if (v[1]) return 1;
    if (v[0]) return 0;
    return (v[15:9] + 1) * 2;
  endfunction

  function automatic int e_den(logic [31:0] v);
    int p;
    if (v[1] || v[0]) return 1;
    p = 1;
    for (int k = 0; k < v[3:2]; k++) p = p * 2;
    return (v[8:4] + 1) * p;
  endfunction

  function automatic int e_mode(logic [31:0] v);
    if (v[1]) return 1;
    if (v[0]) return 0;
    return 2;
  endfunction

  function automatic bit e_legal(logic [31:0] v);
    real r;
    r = real'((v[15:9] + 1) * 2) / real'(v[8:4] + 1);
    return (r >= real'(VMIN)) && (r <= real'(VMAX));
  endfunction

  task automatic wr(logic [1:0] w, logic [31:0] d);
    reg_word  = w;
    reg_wdata = d;
    reg_wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] w, output logic [31:0] d);
    reg_word = w;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_edges(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(MAX_CYCLES * 20);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] v;
    logic [31:0] ctl;
    void'($urandom(32'd20240611));
    wait_edges(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); check("R1 ctrl reset", d, 32'h1);
    rd(2'd1, d); check("R1 status reset", d, 32'h0);
    check("R5 reset mode off", {30'd0, out_mode}, 32'd0);

    // R6 legal directed write, exact lock timing
    v = (32'd23 << 9) | (32'd0 << 4) | (32'd1 << 2);
    wr(2'd0, v);
    check("R3 mult", mult_factor, 32'd48);
    check("R3 den", div_factor, 32'd2);
    check("R6 lock drop", pll_locked, 0);
    wait_edges(LOCK_CYCLES - 1);
    check("R6 not early", pll_locked, 0);
    wait_edges(1);
    check("R6 lock on time", pll_locked, 1);

    // R10 writes to other words ignored while locked
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd2, 32'h0000_0003);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd0, d); check("R10 ctrl unchanged", d, v);
    rd(2'd1, d); check("R10 status read", d, 32'h1);
    rd(2'd2, d); check("R10 meas reads 0", d, 32'h0);
    rd(2'd3, d); check("R10 mon reads 0", d, 32'h0);
    check("R10 lock kept", pll_locked, 1);

    // R7 rewrite at the expiry edge restarts count
    wr(2'd0, v);
    wait_edges(LOCK_CYCLES - 1);
    check("R7 before expiry", pll_locked, 0);
    wr(2'd0, v | (32'd2 << 20));
    check("R7 collide no lock", pll_locked, 0);
    wait_edges(LOCK_CYCLES - 1);
    check("R7 restart not early", pll_locked, 0);
    wait_edges(1);
    check("R7 restart lock", pll_locked, 1);

    // R8 illegal then legal
    wr(2'd0, (32'd3 << 9) | (32'd0 << 4));
    check("R8 err set", pll_error, 1);
    wait_edges(LOCK_CYCLES + 4);
    check("R8 no lock", pll_locked, 0);
    rd(2'd1, d); check("R8 status bits", d, 32'h2);
    wr(2'd0, v);
    check("R8 err cleared", pll_error, 0);
    wait_edges(LOCK_CYCLES);
    check("R8 relock after legal", pll_locked, 1);

    // R4 bypass with power-down set; R9 no relock
    wr(2'd0, v | 32'h3);
    check("R4 mode", {30'd0, out_mode}, 32'd1);
    check("R4 mult", mult_factor, 32'd1);
    check("R4 den", div_factor, 32'd1);
    check("R9 lock cleared", pll_locked, 0);
    wait_edges(LOCK_CYCLES + 2);
    check("R9 stays unlocked", pll_locked, 0);

    // Random stimulus
    for (int it = 0; it < 40; it++) begin
      int sel;
      v = $urandom();
      sel = $urandom_range(0, 7);
      if (sel < 5) v[1:0] = 2'b00;
      else if (sel == 5) v[1:0] = 2'b01;
      wr(2'd0, v);
      ctl = v & 32'h00F0_FFFF;
      rd(2'd0, d); check("R2 readback", d, ctl);
      check("R3 mode", {30'd0, out_mode}, e_mode(v));
      check("R3 mult", mult_factor, e_mult(v));
      check("R3 den", div_factor, e_den(v));
      check("R6 drop", pll_locked, 0);
      if (v[1:0] == 2'b00 && e_legal(v)) begin
        check("R8 err clear", pll_error, 0);
        wait_edges(LOCK_CYCLES - 1);
        check("R6 not early", pll_locked, 0);
        wait_edges(1);
        check("R6 lock", pll_locked, 1);
      end else if (v[1:0] == 2'b00) begin
        check("R8 err", pll_error, 1);
        wait_edges(LOCK_CYCLES + 1);
        check("R8 held", pll_locked, 0);
      end else begin
        check("R9 err clear", pll_error, 0);
        wait_edges(3);
        check("R9 no relock", pll_locked, 0);
      end
    end
    finish_run();
  end
endmodule